// File: doc/BRIEF.md
# Serial NOR Flash Factory ID Fetcher

This block reads the 64-bit factory-programmed identifier out of a serial NOR flash. It uses a single data lane in SPI mode 0. A one-cycle `start` pulse begins a request. The block asks the execute-in-place reader for the shared flash pins and waits for the grant. It then drives chip select low and runs a fixed full-duplex exchange of thirteen bytes. The first byte is the read-identifier command 0x4B. The other twelve bytes are all 0x00. After the exchange it raises chip select, hands the pins back, and reports the identifier with a one-cycle `done` pulse.

The flash answers one byte for every byte sent. The first five received bytes come back while the command and the four dummy bytes go out, and the block drops them. The last eight received bytes form the identifier. The ID leaves on a plain parallel output, with `done` as its only qualifier. There is no back-pressure, so the consumer must take `id_out` when `done` is high or at any time before the next `done`. `id_out` does not change in between. The bus hand-over is a plain level handshake: `bus_req` is held high from the start request until the pins are released, and the block treats `bus_gnt` as meaningful only while `bus_req` is high.

The serial clock comes from the system clock. Each half period lasts `SCLK_HALF` system cycles, and the serial clock is low whenever no bits are moving.

Top module: `uid_fetch`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `bus_req` is 0, `done` is 0 and `id_out` is all zeros.
- R2: A `start` pulse while idle raises `bus_req` on the next cycle. `cs_n` stays 1 for as long as `bus_gnt` is low, however long the grant takes.
- R3: On `mosi` the block sends 0x4B and then twelve bytes of 0x00, each byte MSB first. `mosi` changes only while `sclk` is low, so it never changes while `sclk` is high.
- R4: One transfer has exactly 104 rising edges of `sclk`. Consecutive rising edges are `2*SCLK_HALF` system cycles apart, and `sclk` is low whenever no transfer is running.
- R5: `cs_n` goes low once per transfer, before the first rising edge of `sclk`. It stays low without a break until after the last falling edge, and it never has a rising `sclk` edge while it is high.
- R6: `miso` is sampled on rising `sclk` edges, MSB first. Received bytes 0 to 4 (counted from zero) are discarded whatever their value. Received bytes 5 to 12 form `id_out`, with byte 5 in `id_out[63:56]` and byte 12 in `id_out[7:0]`.
- R7: `bus_req` falls only after `cs_n` has been high for at least one cycle. `done` is asserted in the same cycle that `bus_req` falls.
- R8: `done` lasts exactly one cycle per transfer. `id_out` changes only in the cycle in which `done` is high, and otherwise holds its value.
- R9: A `start` pulse that arrives while a transfer is in progress is ignored. It causes neither a second transfer nor a second `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to fetch the ID |
| bus_req | output | 1 | Asks the execute-in-place reader to give up the flash pins |
| bus_gnt | input | 1 | Execute-in-place reader has stopped and released the pins |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| cs_n | output | 1 | Active-low flash chip select |
| miso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle pulse: `id_out` holds a new ID |
| id_out | output | 8*ID_BYTES | Identifier, first received ID byte in the top byte |

## Verification
The flash model in the bench returns distinct non-zero junk during the command and dummy bytes. A design that kept the wrong window, or one that shifted the window by one byte, would show junk or a rotated pattern in `id_out`. The grant is held back for several cycles in one run, and a design that drove chip select before the grant would be caught with `cs_n` low in that window. One run fires a second `start` in the middle of a transfer. A design that restarted or queued on it would produce an extra `done`, which the scoreboard finds with an empty queue. Stray clock edges outside chip select, a `mosi` change while the clock is high, a wrong edge count, or a bus release in the same cycle as chip select going high would each show up as a failed timing check.

// File: rtl/uidf_pkg.sv
package uidf_pkg;

  // Sequencer states of the ID fetcher
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // waiting for start
    ST_REQ   = 3'd1,  // bus requested, waiting for grant
    ST_SETUP = 3'd2,  // chip select low, first bit settling
    ST_XFER  = 3'd3,  // serial clock running
    ST_CSUP  = 3'd4   // chip select back high, about to release
  } uidf_state_e;

endpackage

// File: rtl/uidf_sclk_gen.sv
module uidf_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic toggle,
  output logic tick,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick     = run && (cnt == CW'(HALF - 1));
  assign rise_evt = tick && toggle && !sclk_q;
  assign fall_evt = tick && toggle &&  sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
    end else if (!run) begin
      sclk_q <= 1'b0;
    end else if (tick && toggle) begin
      sclk_q <= ~sclk_q;
    end
  end

  assign sclk = sclk_q;

  // R4: the serial clock rests low once the divider is stopped
  p_sclk_rest_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q);

endmodule

// File: rtl/uidf_byte_shift.sv
module uidf_byte_shift #(
  parameter int         TOTAL = 13,
  parameter logic [7:0] CMD   = 8'h4B,
  localparam int        IW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          rise,
  input  logic          fall,
  input  logic          miso,
  output logic          mosi,
  output logic          byte_vld,
  output logic [7:0]    byte_val,
  output logic [IW-1:0] byte_idx,
  output logic          all_bits
);

  localparam int BITS = TOTAL * 8;
  localparam int BCW  = $clog2(BITS + 1);

  logic [7:0]     tx_sr;
  logic [6:0]     rx_sr;
  logic [BCW-1:0] rc;

  // transmit: command first, zeros shifted in behind it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= CMD;
    end else if (fall) begin
      tx_sr <= {tx_sr[6:0], 1'b0};
    end
  end

  assign mosi = tx_sr[7];

  // receive: sample on rising edges, count bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0;
      rc    <= '0;
    end else if (load) begin
      rx_sr <= '0;
      rc    <= '0;
    end else if (rise) begin
      rx_sr <= {rx_sr[5:0], miso};
      rc    <= rc + 1'b1;
    end
  end

  assign byte_vld = rise && (rc[2:0] == 3'b111);
  assign byte_val = {rx_sr, miso};
  assign byte_idx = IW'(rc >> 3);
  assign all_bits = (rc == BCW'(BITS));

  // R4: no rising edge beyond the fixed sequence length
  p_no_extra_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (rc < BCW'(BITS)));

  // R3: the transmit register only moves on falling edges or at load
  p_tx_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !load) |=> $stable(tx_sr));

endmodule

// File: rtl/uidf_id_capture.sv
module uidf_id_capture #(
  parameter int  TOTAL = 13,
  parameter int  SKIP  = 5,
  parameter int  IDB   = 8,
  localparam int IW    = $clog2(TOTAL),
  localparam int W     = IDB * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [7:0]    byte_val,
  input  logic [IW-1:0] byte_idx,
  input  logic          commit,
  output logic [W-1:0]  id_q
);

  logic [W-1:0] work;
  logic         keep;

  assign keep = byte_vld && (byte_idx >= IW'(SKIP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work <= '0;
    end else if (keep) begin
      work <= {work[W-9:0], byte_val};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (commit) begin
      id_q <= work;
    end
  end

  // R6: a kept byte never comes from beyond the sequence
  p_keep_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    keep |-> (byte_idx < IW'(TOTAL)));

endmodule

// File: rtl/uid_fetch.sv
module uid_fetch
  import uidf_pkg::*;
#(
  parameter int         SCLK_HALF   = 2,
  parameter logic [7:0] CMD_BYTE    = 8'h4B,
  parameter int         DUMMY_BYTES = 4,
  parameter int         ID_BYTES    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  bus_req,
  input  logic                  bus_gnt,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  cs_n,
  input  logic                  miso,
  output logic                  done,
  output logic [ID_BYTES*8-1:0] id_out
);

  localparam int SKIP  = 1 + DUMMY_BYTES;
  localparam int TOTAL = SKIP + ID_BYTES;
  localparam int IW    = $clog2(TOTAL);

  uidf_state_e st;

  logic          tick, rise_evt, fall_evt;
  logic          run, toggle, load, commit, all_bits;
  logic          byte_vld;
  logic [7:0]    byte_val;
  logic [IW-1:0] byte_idx;

  assign run    = (st == ST_SETUP) || (st == ST_XFER);
  assign toggle = (st == ST_XFER);
  assign load   = (st == ST_REQ) && bus_gnt;
  assign commit = (st == ST_CSUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bus_req <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st      <= ST_REQ;
          bus_req <= 1'b1;
        end
        ST_REQ: if (bus_gnt) begin
          st   <= ST_SETUP;
          cs_n <= 1'b0;
        end
        ST_SETUP: if (tick) st <= ST_XFER;
        ST_XFER: if (fall_evt && all_bits) begin
          st   <= ST_CSUP;
          cs_n <= 1'b1;
        end
        ST_CSUP: begin
          st      <= ST_IDLE;
          bus_req <= 1'b0;
          done    <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  uidf_sclk_gen #(.HALF(SCLK_HALF)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .toggle   (toggle),
    .tick     (tick),
    .sclk     (sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  uidf_byte_shift #(.TOTAL(TOTAL), .CMD(CMD_BYTE)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .rise     (rise_evt),
    .fall     (fall_evt),
    .miso     (miso),
    .mosi     (mosi),
    .byte_vld (byte_vld),
    .byte_val (byte_val),
    .byte_idx (byte_idx),
    .all_bits (all_bits)
  );

  uidf_id_capture #(.TOTAL(TOTAL), .SKIP(SKIP), .IDB(ID_BYTES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .byte_val (byte_val),
    .byte_idx (byte_idx),
    .commit   (commit),
    .id_q     (id_out)
  );

  // R2: chip select only drops after a grant was seen
  p_grant_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(bus_gnt) && bus_req));

  // R5: no serial clock edge outside chip select
  p_sclk_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);

  // R7: bus released only after chip select has been high a cycle
  p_release_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (cs_n && $past(cs_n) && done));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: ID output moves only together with done
  p_id_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_out) |-> done);

endmodule

// File: tb/uid_fetch_test.sv
module uid_fetch_test;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bus_gnt = 1'b0;
  logic        miso = 1'b0;
  logic        bus_req, sclk, mosi, cs_n, done;
  logic [63:0] id_out;

  always #10 clk = ~clk;

  uid_fetch #(.SCLK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .done(done), .id_out(id_out)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- flash responder ----------------
  logic [63:0] cur_pat  = '0;
  logic [7:0]  cur_junk = '0;
  logic [7:0]  rx_bytes [13];
  logic [7:0]  rx_sr = '0;
  int bitn = 0, rises = 0, stray = 0, bad_period = 0, cs_falls = 0;
  realtime last_rise = 0;

  function automatic logic [7:0] resp_byte(input int i);
    if (i < 5) return cur_junk + 8'(i * 8'h11);
    return cur_pat[(63 - 8 * (i - 5)) -: 8];
  endfunction

  always @(negedge cs_n) begin
    bitn = 0;
    cs_falls++;
    miso = resp_byte(0)[7];
  end

  always @(posedge sclk) begin
    if (cs_n) stray++;
    else begin
      if (rises > 0 && ($realtime - last_rise) != 2 * HALF * 20) bad_period++;
      last_rise = $realtime;
      rx_sr = {rx_sr[6:0], mosi};
      bitn++;
      rises++;
      if (bitn % 8 == 0 && bitn <= 104) rx_bytes[bitn / 8 - 1] = rx_sr;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && bitn < 104) miso = resp_byte(bitn / 8)[7 - bitn % 8];
  end

  // ---------------- scoreboard monitor ----------------
  logic [63:0] exp_q [$];
  logic prev_done = 0, prev_req = 0, prev_cs = 1, prev_sclk = 0, prev_mosi = 0;
  int mosi_hi_chg = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected done", id_out, '0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(id_out == e, "R6 id window", id_out, e);
        end
      end
      if (prev_done && done) chk(0, "R8 done longer than one cycle", 1, 0);
      if (prev_req && !bus_req) begin
        chk(prev_cs && cs_n, "R7 release after cs high", {62'd0, prev_cs, cs_n}, 64'd3);
        chk(done, "R7 done with release", done, 1);
      end
      if (prev_sclk && sclk && mosi != prev_mosi) mosi_hi_chg++;
      prev_done = done; prev_req = bus_req; prev_cs = cs_n;
      prev_sclk = sclk; prev_mosi = mosi;
    end
  end

  // ---------------- driver ----------------
  task automatic run_fetch(input logic [63:0] pat, input logic [7:0] junk,
                           input int gnt_delay, input bit poke);
    exp_q.push_back(pat);
    cur_pat = pat; cur_junk = junk;
    rises = 0; stray = 0; bad_period = 0; cs_falls = 0; mosi_hi_chg = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(bus_req == 1'b1, "R2 bus_req after start", bus_req, 1);
    for (int i = 0; i < gnt_delay; i++) begin
      @(negedge clk);
      chk(cs_n == 1'b1, "R2 cs_n held until grant", cs_n, 1);
    end
    bus_gnt = 1'b1;
    if (poke) begin
      wait (!cs_n);
      repeat (20) @(negedge clk);
      start = 1'b1;               // R9: ignored mid-transfer
      @(negedge clk) start = 1'b0;
    end
    @(negedge clk);
    while (bus_req) @(negedge clk);
    bus_gnt = 1'b0;
    chk(rises == 104, "R4 rising edge count", rises, 104);
    chk(bad_period == 0, "R4 sclk period", bad_period, 0);
    chk(sclk == 1'b0, "R4 sclk idle low", sclk, 0);
    chk(stray == 0 && cs_falls == 1, "R5 cs_n unbroken", {stray[31:0], cs_falls[31:0]}, 64'd1);
    chk(rx_bytes[0] == 8'h4B, "R3 command byte", rx_bytes[0], 8'h4B);
    for (int b = 1; b < 13; b++)
      chk(rx_bytes[b] == 8'h00, "R3 zero fill byte", rx_bytes[b], 0);
    chk(mosi_hi_chg == 0, "R3 mosi stable while sclk high", mosi_hi_chg, 0);
    repeat (30) @(negedge clk);
    chk(id_out == pat, "R8 id_out held", id_out, pat);
    chk(bus_req == 1'b0 && done == 1'b0, "R9 no second transfer", {bus_req, done}, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    chk(bus_req == 1'b0, "R1 reset bus_req", bus_req, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(id_out == '0, "R1 reset id_out", id_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_fetch(64'h0123_4567_89AB_CDEF, 8'hA5, 0, 1'b0);
    run_fetch(64'hFEDC_BA98_7654_3210, 8'h3C, 7, 1'b1);
    run_fetch(64'h8000_0000_0000_0001, 8'hFF, 2, 1'b0);
    chk(exp_q.size() == 0, "R8 every request answered", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule